// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Sequencer

This block moves one 16-bit word at a time between the chip and a three-wire serial EEPROM (select, clock, data out, data in). A one-cycle start request carries a read or write select, a byte offset and the word to write. The block then drives the serial lines on its own until the operation is over. The word address sent to the memory is the byte offset with its lowest bit dropped.

A read is a single select frame. It carries the read command and address, then 16 further clock pulses during which the memory returns the word. A write is a fixed chain of steps:
- an enable frame;
- a write frame carrying command, address and data;
- a short deselect, then a reselect during which the data-in line is polled until the memory reports ready or a check limit runs out;
- a disable frame.

All lines return low at the end of both kinds of operation, and a one-cycle done pulse marks completion. The serial clock is derived from the system clock by a parameterized divider.

Top module: `serial_eeprom_seq`

## Requirements
- R1: After reset, and while idle, eeCs, eeSclk, eeDout, eeDinEn, done and timedOut are all low.
- R2: Every select frame is preceded by at least CLK_DIV cycles with eeCs, eeSclk and eeDout all low. eeSclk is only ever high while eeCs is high.
- R3: Bits are sent most significant first. eeDout changes only while eeSclk is low. Each clock high phase and each clock low phase inside a frame lasts at least CLK_DIV cycles.
- R4: A command is 11 bits: a start bit 1, a 2-bit opcode, then the 8-bit word address (byteOffset[8:1]; byteOffset[0] is ignored). Read uses opcode 10 and write uses 01. Enable uses opcode 00 with address 11000000, and disable uses opcode 00 with address 00000000.
- R5: A write produces exactly four select frames, in this order:
  - the 11-bit enable frame;
  - a 27-bit frame of the write command followed by wrData, MSB first;
  - a frame with no clock pulses, used for the ready poll;
  - the 11-bit disable frame.
- R6: During the poll, eeDin is checked every POLL_GAP cycles, and the first high check ends the poll. After POLL_LIMIT low checks, timedOut is set and the disable frame is still sent. timedOut holds until the next accepted start clears it.
- R7: A read is one frame of 27 clock pulses: the 11 command bits, then 16 receive pulses. eeDin is sampled at the end of each receive high phase, and the first bit received lands in rdData[15].
- R8: eeDinEn is high only during the 16 receive pulses of a read, and it stays low throughout a write.
- R9: done is high for exactly one cycle per operation. In that cycle all serial lines are low.
- R10: A start request that arrives while an operation is running is ignored and does not change the frames or the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe, accepted only when idle |
| isWrite | input | 1 | 1 selects a write, 0 a read |
| byteOffset | input | 9 | Byte offset; the word address is bits 8:1 |
| wrData | input | 16 | Word to write |
| rdData | output | 16 | Word returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | Set when the write ready poll ran out of checks |
| eeCs | output | 1 | Memory chip select |
| eeSclk | output | 1 | Serial clock |
| eeDout | output | 1 | Serial data to the memory |
| eeDin | input | 1 | Serial data and ready status from the memory |
| eeDinEn | output | 1 | Enable for the data-in receive path |

## Verification
The checker watches the line discipline on every cycle. It checks that the clock is only high inside a select, that data out holds still through each high phase, and that both clock phases last at least CLK_DIV cycles. It also checks that each select rises out of an all-low interval, that the receive enable stays inside a select, and that done lasts one cycle with the lines low. Frame contents, the order of the write steps, address halving, bit order of received data, poll completion against timeout and the ignoring of a start while busy can only be shown by the bench. Its memory model decodes the frames, answers reads and reports busy after each programmed word.

// File: rtl/serial_eeprom_seq_pkg.sv
package serial_eeprom_seq_pkg;

  typedef enum logic [1:0] {
    FR_WREN  = 2'd0,
    FR_WRITE = 2'd1,
    FR_WRDS  = 2'd2,
    FR_READ  = 2'd3
  } frame_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_QUIET, ST_SEL, ST_LO, ST_HI,
    ST_GAP, ST_RESEL, ST_POLL, ST_END
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;  // latch request fields
    logic   load;     // load shifter with current frame
    logic   shift;    // advance shifter one bit
    logic   sample;   // shift eeDin into read word
    logic   drive;    // present shifter MSB on data out
    frame_e frame;
  } strobe_t;

endpackage

// File: rtl/serial_eeprom_seq_datapath.sv
module serial_eeprom_seq_datapath
  import serial_eeprom_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              din,
  output logic              dout,
  output logic [DATA_W-1:0] rdData
);
  localparam int CMD_LEN  = 3 + ADDR_W;
  localparam int FULL_LEN = CMD_LEN + DATA_W;

  logic [ADDR_W-1:0]   addrQ;
  logic [DATA_W-1:0]   dataQ;
  logic [FULL_LEN-1:0] shiftReg;
  logic [CMD_LEN-1:0]  head;

  // command word: start bit, opcode, address
  always_comb begin
    unique case (strobes.frame)
      FR_WREN:  head = {3'b100, 2'b11, {(ADDR_W-2){1'b0}}};
      FR_WRITE: head = {3'b101, addrQ};
      FR_WRDS:  head = {3'b100, {ADDR_W{1'b0}}};
      default:  head = {3'b110, addrQ};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      shiftReg <= '0;
      rdData   <= '0;
    end else begin
      if (strobes.capture) begin
        addrQ <= wordAddr;
        dataQ <= wrData;
      end
      if (strobes.load)
        shiftReg <= {head, (strobes.frame == FR_WRITE) ? dataQ : {DATA_W{1'b0}}};
      else if (strobes.shift)
        shiftReg <= {shiftReg[FULL_LEN-2:0], 1'b0};
      if (strobes.sample)
        rdData <= {rdData[DATA_W-2:0], din};
    end
  end

  assign dout = strobes.drive & shiftReg[FULL_LEN-1];

endmodule

// File: rtl/serial_eeprom_seq_control.sv
module serial_eeprom_seq_control
  import serial_eeprom_seq_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int POLL_GAP   = 1250,
  parameter int POLL_LIMIT = 20000,
  parameter int CMD_LEN    = 11,
  parameter int DATA_W     = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    isWrite,
  input  logic    din,
  output strobe_t strobes,
  output logic    cs,
  output logic    sclk,
  output logic    dinEn,
  output logic    done,
  output logic    timedOut
);
  localparam int FULL_LEN = CMD_LEN + DATA_W;
  localparam int DIV_W    = $clog2(CLK_DIV + 1);
  localparam int GAP_W    = $clog2(POLL_GAP + 1);
  localparam int CNT_W    = $clog2(POLL_LIMIT + 1);
  localparam int REM_W    = $clog2(FULL_LEN + 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLK_DIV - 1);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(POLL_GAP - 1);
  localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_LIMIT - 1);

  state_e            state;
  frame_e            frame;
  logic [DIV_W-1:0]  divCnt;
  logic [GAP_W-1:0]  pollTimer;
  logic [CNT_W-1:0]  pollCount;
  logic [REM_W-1:0]  remaining;
  logic              tick;
  logic              bitPhase;
  logic              receiving;

  assign tick      = (divCnt == DIV_LAST);
  assign bitPhase  = (state == ST_LO) || (state == ST_HI);
  assign receiving = (frame == FR_READ) && (remaining <= REM_W'(DATA_W));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frame     <= FR_READ;
      divCnt    <= '0;
      pollTimer <= '0;
      pollCount <= '0;
      remaining <= '0;
      done      <= 1'b0;
      timedOut  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE || state == ST_POLL || tick) divCnt <= '0;
      else                                              divCnt <= divCnt + 1'b1;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_QUIET;
          frame    <= isWrite ? FR_WREN : FR_READ;
          timedOut <= 1'b0;
        end
        ST_QUIET: if (tick) state <= ST_SEL;
        ST_SEL: if (tick) begin
          state     <= ST_LO;
          remaining <= (frame == FR_WRITE || frame == FR_READ) ? REM_W'(FULL_LEN)
                                                               : REM_W'(CMD_LEN);
        end
        ST_LO: if (tick) state <= ST_HI;
        ST_HI: if (tick) begin
          remaining <= remaining - 1'b1;
          if (remaining == REM_W'(1)) begin
            unique case (frame)
              FR_WREN:  begin frame <= FR_WRITE; state <= ST_QUIET; end
              FR_WRITE: state <= ST_GAP;
              default:  state <= ST_END;
            endcase
          end else begin
            state <= ST_LO;
          end
        end
        ST_GAP: if (tick) state <= ST_RESEL;
        ST_RESEL: if (tick) begin
          state     <= ST_POLL;
          pollTimer <= '0;
          pollCount <= '0;
        end
        ST_POLL: begin
          if (pollTimer == GAP_LAST) begin
            pollTimer <= '0;
            if (din) begin
              frame <= FR_WRDS;
              state <= ST_QUIET;
            end else if (pollCount == POLL_LAST) begin
              timedOut <= 1'b1;
              frame    <= FR_WRDS;
              state    <= ST_QUIET;
            end else begin
              pollCount <= pollCount + 1'b1;
            end
          end else begin
            pollTimer <= pollTimer + 1'b1;
          end
        end
        ST_END: if (tick) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = (state == ST_IDLE) && start;
    strobes.load    = (state == ST_QUIET) && tick;
    strobes.shift   = (state == ST_HI) && tick;
    strobes.sample  = (state == ST_HI) && tick && receiving;
    strobes.drive   = bitPhase;
    strobes.frame   = frame;
  end

  assign cs    = (state == ST_SEL) || bitPhase || (state == ST_RESEL) || (state == ST_POLL);
  assign sclk  = (state == ST_HI);
  assign dinEn = bitPhase && receiving;

endmodule

// File: rtl/serial_eeprom_seq.sv
module serial_eeprom_seq
  import serial_eeprom_seq_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int POLL_GAP   = 1250,
  parameter int POLL_LIMIT = 20000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  input  logic [ADDR_W:0]   byteOffset,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              timedOut,
  output logic              eeCs,
  output logic              eeSclk,
  output logic              eeDout,
  input  logic              eeDin,
  output logic              eeDinEn
);
  strobe_t strobes;
  logic    unusedLsb;

  assign unusedLsb = byteOffset[0];

  serial_eeprom_seq_control #(
    .CLK_DIV(CLK_DIV), .POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT),
    .CMD_LEN(3 + ADDR_W), .DATA_W(DATA_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .din(eeDin),
    .strobes(strobes), .cs(eeCs), .sclk(eeSclk), .dinEn(eeDinEn),
    .done(done), .timedOut(timedOut)
  );

  serial_eeprom_seq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordAddr(byteOffset[ADDR_W:1]),
    .wrData(wrData), .din(eeDin), .dout(eeDout), .rdData(rdData)
  );

endmodule

// File: rtl/serial_eeprom_seq_chk.sv
module serial_eeprom_seq_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic eeCs,
  input logic eeSclk,
  input logic eeDout,
  input logic eeDinEn,
  input logic done
);
  logic [15:0] hiLen;
  logic [15:0] loLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiLen <= '0;
      loLen <= '0;
    end else begin
      hiLen <= eeSclk ? ((hiLen == 16'hFFFF) ? hiLen : hiLen + 1'b1) : 16'd0;
      loLen <= (eeCs && !eeSclk) ? ((loLen == 16'hFFFF) ? loLen : loLen + 1'b1) : 16'd0;
    end
  end

  a_r2_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    eeSclk |-> eeCs);

  a_r2_select_from_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> $past(!eeSclk && !eeDout));

  a_r3_dout_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    (eeSclk && $past(eeSclk)) |-> $stable(eeDout));

  a_r3_high_phase_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeSclk) |-> (hiLen >= 16'(CLK_DIV)));

  a_r3_low_phase_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeSclk) |-> (loLen >= 16'(CLK_DIV)));

  a_r8_dinen_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    eeDinEn |-> eeCs);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_lines_low: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!eeCs && !eeSclk && !eeDout && !eeDinEn));

endmodule

bind serial_eeprom_seq serial_eeprom_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .eeCs(eeCs), .eeSclk(eeSclk),
  .eeDout(eeDout), .eeDinEn(eeDinEn), .done(done)
);

// File: tb/test_serial_eeprom_seq.sv
module test_serial_eeprom_seq;
  localparam int CLK_DIV    = 2;
  localparam int POLL_GAP   = 4;
  localparam int POLL_LIMIT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isWrite = 1'b0;
  logic [8:0]  byteOffset = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        done, timedOut, eeCs, eeSclk, eeDout, eeDinEn;
  logic        eeDin = 1'b1;

  always #4 clk = ~clk;

  serial_eeprom_seq #(
    .CLK_DIV(CLK_DIV), .POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)
  ) i_serial_eeprom_seq (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
    .byteOffset(byteOffset), .wrData(wrData), .rdData(rdData), .done(done),
    .timedOut(timedOut), .eeCs(eeCs), .eeSclk(eeSclk), .eeDout(eeDout),
    .eeDin(eeDin), .eeDinEn(eeDinEn)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // memory model and frame log
  logic [15:0] mem    [256];
  logic [15:0] refMem [256];
  logic        wen = 1'b0;
  int          busyCnt = 0;
  int          busyLen = 0;
  logic        prevCs = 1'b0, prevSclk = 1'b0;
  logic [26:0] curBits = '0;
  int          curLen = 0;
  logic [7:0]  rdAddr = '0;
  logic        rdMode = 1'b0, rdBit = 1'b0;
  int          frCount = 0;
  int          frLen  [8];
  logic [26:0] frBits [8];
  int          doneCnt = 0;
  int          dinEnCnt = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
      refMem[i] = mem[i];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (busyCnt > 0) busyCnt--;
    if (eeCs && !prevCs) begin
      curLen = 0; curBits = '0;
    end
    if (eeSclk && !prevSclk) begin
      curBits = {curBits[25:0], eeDout};
      curLen++;
      if (curLen == 11) begin
        rdAddr = curBits[7:0];
        rdMode = (curBits[10:8] == 3'b110);
      end
      if (rdMode && curLen >= 12 && curLen <= 27) rdBit = mem[rdAddr][27 - curLen];
    end
    if (!eeCs && prevCs) begin
      if (frCount < 8) begin
        frLen[frCount]  = curLen;
        frBits[frCount] = curBits;
      end
      frCount++;
      if (curLen == 11 && curBits[10:8] == 3'b100) begin
        if (curBits[7:6] == 2'b11) wen = 1'b1;
        else if (curBits[7:6] == 2'b00) wen = 1'b0;
      end
      if (curLen == 27 && curBits[26:24] == 3'b101) begin
        if (wen) mem[curBits[23:16]] = curBits[15:0];
        busyCnt = busyLen;
      end
      rdMode = 1'b0;
    end
    eeDin <= rdMode ? rdBit : (busyCnt == 0);
    if (eeDinEn) dinEnCnt++;
    if (done) doneCnt++;
    prevCs = eeCs;
    prevSclk = eeSclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startOp(input logic wr, input logic [8:0] off, input logic [15:0] data, input int busy);
    @(negedge clk);
    frCount = 0; doneCnt = 0; dinEnCnt = 0; busyLen = busy;
    isWrite = wr; byteOffset = off; wrData = data; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (doneCnt == 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkWriteFrames(input string req, input logic [7:0] a, input logic [15:0] d);
    chk(frCount == 4, {req, " frame count"}, 32'(frCount), 32'd4);
    chk(frLen[0] == 11 && frBits[0][10:0] == 11'b100_1100_0000, {req, " enable frame"},
        32'(frBits[0]), 32'h4C0);
    chk(frLen[1] == 27 && frBits[1] == {3'b101, a, d}, {req, " write frame"},
        32'(frBits[1]), 32'({3'b101, a, d}));
    chk(frLen[2] == 0, {req, " poll frame no pulses"}, 32'(frLen[2]), 32'd0);
    chk(frLen[3] == 11 && frBits[3][10:0] == 11'b100_0000_0000, {req, " disable frame"},
        32'(frBits[3]), 32'h400);
  endtask

  // {isWrite, byteOffset, data, busy, expected timeout}
  localparam logic [42:0] VEC [6] = '{
    {1'b1, 9'h010, 16'hBEEF, 16'd0,  1'b0},
    {1'b0, 9'h010, 16'h0000, 16'd0,  1'b0},
    {1'b1, 9'h0A7, 16'h1234, 16'd20, 1'b0},
    {1'b0, 9'h0A6, 16'h0000, 16'd0,  1'b0},
    {1'b0, 9'h1FE, 16'h0000, 16'd0,  1'b0},
    {1'b1, 9'h002, 16'h8001, 16'd20, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({eeCs, eeSclk, eeDout, eeDinEn, done, timedOut} == 6'b0, "R1 lines low in reset",
        32'({eeCs, eeSclk, eeDout, eeDinEn, done, timedOut}), 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk({eeCs, eeSclk, eeDout, eeDinEn, done, timedOut} == 6'b0, "R1 lines low when idle",
        32'({eeCs, eeSclk, eeDout, eeDinEn, done, timedOut}), 32'd0);

    for (int v = 0; v < 6; v++) begin
      logic        wr  = VEC[v][42];
      logic [8:0]  off = VEC[v][41:33];
      logic [15:0] dat = VEC[v][32:17];
      startOp(wr, off, dat, int'(VEC[v][16:1]));
      waitDone();
      chk(doneCnt == 1, "R9 one done pulse", 32'(doneCnt), 32'd1);
      chk(timedOut == VEC[v][0], "R6 timeout flag", 32'(timedOut), 32'(VEC[v][0]));
      if (wr) begin
        refMem[off[8:1]] = dat;
        checkWriteFrames("R5 R4", off[8:1], dat);
        chk(dinEnCnt == 0, "R8 no receive enable in write", 32'(dinEnCnt), 32'd0);
      end else begin
        chk(frCount == 1 && frLen[0] == 27, "R7 read frame pulses", 32'(frLen[0]), 32'd27);
        chk(frBits[0][26:16] == {3'b110, off[8:1]}, "R4 read command",
            32'(frBits[0][26:16]), 32'({3'b110, off[8:1]}));
        chk(rdData == refMem[off[8:1]], "R7 read data", 32'(rdData), 32'(refMem[off[8:1]]));
        chk(dinEnCnt == 16 * 2 * CLK_DIV, "R8 receive enable window", 32'(dinEnCnt),
            32'(16 * 2 * CLK_DIV));
      end
    end

    // R6 poll timeout: disable still sent, flag held, then cleared by next start
    startOp(1'b1, 9'h040, 16'hC3A5, 300);
    waitDone();
    refMem[8'h20] = 16'hC3A5;
    chk(timedOut == 1'b1, "R6 timeout set", 32'(timedOut), 32'd1);
    checkWriteFrames("R6 timeout sequence", 8'h20, 16'hC3A5);
    repeat (10) @(negedge clk);
    chk(timedOut == 1'b1, "R6 timeout held", 32'(timedOut), 32'd1);
    busyCnt = 0;
    startOp(1'b0, 9'h040, 16'h0000, 0);
    chk(timedOut == 1'b0, "R6 timeout cleared on start", 32'(timedOut), 32'd0);
    waitDone();
    chk(rdData == 16'hC3A5, "R7 read after timed-out write", 32'(rdData), 32'hC3A5);

    // R10 start while busy ignored
    startOp(1'b1, 9'h0F0, 16'h7E81, 20);
    repeat (30) @(negedge clk);
    isWrite = 1'b0; byteOffset = 9'h100; wrData = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    refMem[8'h78] = 16'h7E81;
    checkWriteFrames("R10 busy start ignored", 8'h78, 16'h7E81);
    chk(doneCnt == 1, "R10 single completion", 32'(doneCnt), 32'd1);
    repeat (20) @(negedge clk);
    chk(eeCs == 1'b0 && frCount == 4, "R10 no second operation", 32'(frCount), 32'd4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule